// File: doc/BRIEF.md
# Store Conflict Filter Table

This block lets a load read the data cache before the addresses of older stores are known. It keeps one sticky bit per store instruction address (PC), held in a table indexed by the low PC bits. A bit is set the first time that store hands its data straight to a load inside the load/store queue. Until a store has done that, it is treated as harmless.

Each query carries a load address and up to four older, still-unresolved store descriptors. Each descriptor holds a valid flag, the store PC index, a confidence flag and a predicted store address. The block answers one cycle later. It says whether the load may go early and which slots held it back. A slot holds the load back only if its store's bit is set and no confident predicted address shows a different memory word.

A second port receives store resolutions. When a resolved store hits the same word as a load that already went early past it, the block raises a one-cycle flush request. That request tells the pipeline to discard everything younger than that load.

Top module: `store_conflict_filter`

## Requirements
- R1: A synchronous reset clears every table bit, so after reset no store PC blocks a load.
- R2: A pulse on `fwd_set_valid` sets the bit of `fwd_set_pc` from the next cycle on. The bit stays set across any later activity until reset.
- R3: A valid slot whose store bit is clear never blocks the load, whatever its addresses.
- R4: A valid slot whose store bit is set and whose confidence flag is low blocks the load.
- R5: A valid slot whose store bit is set and whose confidence flag is high blocks the load only when the predicted address and the load address agree in bits [ADDR_W-1:2]. The word is 4 bytes, and the two lowest address bits are ignored.
- R6: A slot whose valid bit is low has no effect on the answer.
- R7: The answer appears on the clock edge after the query. `ans_valid` equals the previous cycle's `qry_valid`. `ans_early` is high only when `ans_valid` is high and no slot blocks. `ans_block_mask` bit i flags slot i. Without a query, all three outputs are 0.
- R8: A set and a query for the same PC in the same cycle are resolved with the table as it was before the set.
- R9: `flush_req` is high for the cycle after a resolution whose `res_load_early` is high and whose store and load addresses agree in bits [ADDR_W-1:2]. Otherwise it is low.
- R10: During reset, all outputs read 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_set_valid | input | 1 | A store forwarded data to a load this cycle |
| fwd_set_pc | input | IDX_W (10) | Table index of the forwarding store |
| qry_valid | input | 1 | Early-issue query present |
| qry_load_addr | input | ADDR_W (32) | Address of the querying load |
| qry_slot_valid | input | SLOTS (4) | Per-slot older unresolved store present |
| qry_slot_pc | input | SLOTS*IDX_W | Per-slot store table index, slot i at [i*IDX_W +: IDX_W] |
| qry_slot_conf | input | SLOTS | Per-slot predicted address is high-confidence |
| qry_slot_pred_addr | input | SLOTS*ADDR_W | Per-slot predicted store address |
| res_valid | input | 1 | A store address resolved against a load |
| res_store_addr | input | ADDR_W | Resolved store address |
| res_load_addr | input | ADDR_W | Address of the younger load |
| res_load_early | input | 1 | That load issued early past the store |
| ans_valid | output | 1 | Answer present |
| ans_early | output | 1 | Load may issue early |
| ans_block_mask | output | SLOTS | Slots that blocked the load |
| flush_req | output | 1 | One-cycle request to flush younger instructions |

## Verification
A table bit that is wrongly set or lost shows up as a wrong `ans_early` on the first query naming that PC without a distinguishing confident prediction. That query is answered one cycle later, so such faults surface within a cycle of being exercised. A wrong word comparison shows either as a spurious block when prediction bytes differ only inside a word, or as a missed or extra `flush_req` on the cycle after a resolution. The bench's reference model tracks every bit and compares all outputs on every clock, so a fault is reported on the first cycle it reaches the ports.

// File: rtl/scf_pkg.sv
package scf_pkg;
  // Compare two addresses above a word offset; widths up to 64 bits.
  function automatic logic word_match(input logic [63:0] a, input logic [63:0] b,
                                      input int lsb, input int w);
    logic [63:0] mask;
    mask = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    return ((((a ^ b) & mask) >> lsb) == 64'd0);
  endfunction
endpackage

// File: rtl/scf_bit_table.sv
module scf_bit_table #(
  parameter int ENTRIES  = 1024,
  parameter int IDX_W    = 10,
  parameter int RD_PORTS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [RD_PORTS*IDX_W-1:0] rd_idx,
  output logic [RD_PORTS-1:0]       rd_bit
);
  logic [ENTRIES-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= 1'b1;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_bit[p] = bits_q[rd_idx[p*IDX_W +: IDX_W]];
  end

  // R2: a set is visible on the next cycle
  p_set_visible_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> bits_q[$past(wr_idx)]);
  // R2: bits only ever rise outside reset
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/scf_slot_check.sv
module scf_slot_check #(
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic              slot_valid,
  input  logic              conflict_bit,
  input  logic              pred_conf,
  input  logic [ADDR_W-1:0] pred_addr,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              blocks
);
  import scf_pkg::*;
  logic same_word;

  always_comb begin
    same_word = word_match(64'(pred_addr), 64'(load_addr), WORD_LSB, ADDR_W);
    blocks    = slot_valid && conflict_bit && (!pred_conf || same_word);
  end

  // R3/R6: a clear bit or an empty slot never blocks
  always_comb begin
    if (!slot_valid || !conflict_bit) a_clear_no_block_r3: assert (!blocks);
  end
endmodule

// File: rtl/scf_flush_gen.sv
module scf_flush_gen #(
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_store_addr,
  input  logic [ADDR_W-1:0] res_load_addr,
  input  logic              res_load_early,
  output logic              flush_req
);
  import scf_pkg::*;
  logic hit;

  assign hit = res_valid && res_load_early &&
               word_match(64'(res_store_addr), 64'(res_load_addr), WORD_LSB, ADDR_W);

  always_ff @(posedge clk) begin
    if (rst) flush_req <= 1'b0;
    else     flush_req <= hit;
  end

  // R9: a resolution for a load that waited never flushes
  p_no_flush_if_waited_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_load_early) |=> !flush_req);
  // R9: no resolution, no flush
  p_flush_needs_res_r9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !flush_req);
endmodule

// File: rtl/store_conflict_filter.sv
module store_conflict_filter #(
  parameter int ENTRIES  = 1024,
  parameter int SLOTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fwd_set_valid,
  input  logic [IDX_W-1:0]          fwd_set_pc,
  input  logic                      qry_valid,
  input  logic [ADDR_W-1:0]         qry_load_addr,
  input  logic [SLOTS-1:0]          qry_slot_valid,
  input  logic [SLOTS*IDX_W-1:0]    qry_slot_pc,
  input  logic [SLOTS-1:0]          qry_slot_conf,
  input  logic [SLOTS*ADDR_W-1:0]   qry_slot_pred_addr,
  input  logic                      res_valid,
  input  logic [ADDR_W-1:0]         res_store_addr,
  input  logic [ADDR_W-1:0]         res_load_addr,
  input  logic                      res_load_early,
  output logic                      ans_valid,
  output logic                      ans_early,
  output logic [SLOTS-1:0]          ans_block_mask,
  output logic                      flush_req
);
  logic [SLOTS-1:0] slot_bit;
  logic [SLOTS-1:0] slot_blocks;

  scf_bit_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RD_PORTS(SLOTS)) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (fwd_set_valid),
    .wr_idx (fwd_set_pc),
    .rd_idx (qry_slot_pc),
    .rd_bit (slot_bit)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    scf_slot_check #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_chk (
      .slot_valid   (qry_slot_valid[s]),
      .conflict_bit (slot_bit[s]),
      .pred_conf    (qry_slot_conf[s]),
      .pred_addr    (qry_slot_pred_addr[s*ADDR_W +: ADDR_W]),
      .load_addr    (qry_load_addr),
      .blocks       (slot_blocks[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ans_valid      <= 1'b0;
      ans_early      <= 1'b0;
      ans_block_mask <= '0;
    end else begin
      ans_valid      <= qry_valid;
      ans_early      <= qry_valid && (slot_blocks == '0);
      ans_block_mask <= qry_valid ? slot_blocks : '0;
    end
  end

  scf_flush_gen #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_flush (
    .clk            (clk),
    .rst            (rst),
    .res_valid      (res_valid),
    .res_store_addr (res_store_addr),
    .res_load_addr  (res_load_addr),
    .res_load_early (res_load_early),
    .flush_req      (flush_req)
  );

  // R7: answer tracks the query one cycle later
  p_answer_follows_r7: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> ans_valid);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> (!ans_valid && !ans_early && ans_block_mask == '0));
  // R7: early grant only with an empty block mask
  p_early_clean_r7: assert property (@(posedge clk) disable iff (rst)
    ans_early |-> (ans_valid && ans_block_mask == '0));
  // R10: outputs cleared after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!ans_valid && !ans_early && !flush_req));
endmodule

// File: tb/sim_store_conflict_filter.sv
`timescale 1ns/1ps
module sim_store_conflict_filter;
  localparam int ENTRIES = 1024;
  localparam int SLOTS   = 4;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic                    fwd_set_valid = 0;
  logic [IDX_W-1:0]        fwd_set_pc = '0;
  logic                    qry_valid = 0;
  logic [ADDR_W-1:0]       qry_load_addr = '0;
  logic [SLOTS-1:0]        qry_slot_valid = '0;
  logic [SLOTS*IDX_W-1:0]  qry_slot_pc = '0;
  logic [SLOTS-1:0]        qry_slot_conf = '0;
  logic [SLOTS*ADDR_W-1:0] qry_slot_pred_addr = '0;
  logic                    res_valid = 0;
  logic [ADDR_W-1:0]       res_store_addr = '0;
  logic [ADDR_W-1:0]       res_load_addr = '0;
  logic                    res_load_early = 0;
  logic                    ans_valid, ans_early, flush_req;
  logic [SLOTS-1:0]        ans_block_mask;

  always #10 clk = ~clk;

  store_conflict_filter u0 (
    .clk(clk), .rst(rst),
    .fwd_set_valid(fwd_set_valid), .fwd_set_pc(fwd_set_pc),
    .qry_valid(qry_valid), .qry_load_addr(qry_load_addr),
    .qry_slot_valid(qry_slot_valid), .qry_slot_pc(qry_slot_pc),
    .qry_slot_conf(qry_slot_conf), .qry_slot_pred_addr(qry_slot_pred_addr),
    .res_valid(res_valid), .res_store_addr(res_store_addr),
    .res_load_addr(res_load_addr), .res_load_early(res_load_early),
    .ans_valid(ans_valid), .ans_early(ans_early),
    .ans_block_mask(ans_block_mask), .flush_req(flush_req)
  );

  bit tbl [ENTRIES];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string tag   = "R10";

  // One clock: predict from current inputs and model, step, compare.
  task automatic cyc();
    logic e_valid, e_early, e_flush;
    logic [SLOTS-1:0] e_mask;
    e_mask = '0;
    for (int s = 0; s < SLOTS; s++) begin
      int pc;
      logic [ADDR_W-1:0] pa;
      pc = int'(qry_slot_pc[s*IDX_W +: IDX_W]);
      pa = qry_slot_pred_addr[s*ADDR_W +: ADDR_W];
      if (qry_slot_valid[s] && tbl[pc] &&
          (!qry_slot_conf[s] || (pa >> 2) == (qry_load_addr >> 2)))
        e_mask[s] = 1'b1;
    end
    if (rst) begin
      e_valid = 0; e_early = 0; e_mask = '0; e_flush = 0;
    end else begin
      e_valid = qry_valid;
      e_early = qry_valid && (e_mask == '0);
      if (!qry_valid) e_mask = '0;
      e_flush = res_valid && res_load_early &&
                ((res_store_addr >> 2) == (res_load_addr >> 2));
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] = 0;
    end else if (fwd_set_valid) tbl[int'(fwd_set_pc)] = 1;
    #5;
    n_checks++;
    if (ans_valid !== e_valid || ans_early !== e_early ||
        ans_block_mask !== e_mask || flush_req !== e_flush) begin
      n_fail++;
      $display("FAIL %s: got valid=%b early=%b mask=%b flush=%b exp valid=%b early=%b mask=%b flush=%b",
               tag, ans_valid, ans_early, ans_block_mask, flush_req,
               e_valid, e_early, e_mask, e_flush);
    end
  endtask

  task automatic idle();
    fwd_set_valid = 0; qry_valid = 0; res_valid = 0; res_load_early = 0;
    qry_slot_valid = '0; qry_slot_conf = '0;
  endtask

  task automatic set_slot(int s, bit v, int pc, bit conf, logic [ADDR_W-1:0] pa);
    qry_slot_valid[s] = v;
    qry_slot_pc[s*IDX_W +: IDX_W] = IDX_W'(pc);
    qry_slot_conf[s] = conf;
    qry_slot_pred_addr[s*ADDR_W +: ADDR_W] = pa;
  endtask

  task automatic query(logic [ADDR_W-1:0] la);
    qry_valid = 1; qry_load_addr = la;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < ENTRIES; i++) tbl[i] = 0;
    // R10 / R1: reset state
    tag = "R10"; rst = 1; cyc(); cyc();
    rst = 0; idle(); tag = "R7"; cyc();

    // R1 / R3: all bits clear, same address, no prediction -> early
    tag = "R3"; idle(); query(32'h1000);
    for (int s = 0; s < SLOTS; s++) set_slot(s, 1, s + 5, 0, 32'h1000);
    cyc();

    // R2: set pc 5 then query it -> R4 block on slot 0
    tag = "R2"; idle(); fwd_set_valid = 1; fwd_set_pc = 10'd5; cyc();
    tag = "R4"; idle(); query(32'h2000); set_slot(0, 1, 5, 0, 32'h0); cyc();
    // R5: confident, different word -> early; same word other byte -> block
    tag = "R5"; idle(); query(32'h2000); set_slot(2, 1, 5, 1, 32'h2004); cyc();
    tag = "R5"; idle(); query(32'h2000); set_slot(3, 1, 5, 1, 32'h2003); cyc();
    // R6: invalid slot naming a set pc has no effect
    tag = "R6"; idle(); query(32'h2000); set_slot(1, 0, 5, 0, 32'h2000); cyc();
    // R8: same-cycle set and query sees old table
    tag = "R8"; idle(); fwd_set_valid = 1; fwd_set_pc = 10'd9;
    query(32'h40); set_slot(0, 1, 9, 0, 32'h40); cyc();
    tag = "R8"; idle(); query(32'h40); set_slot(0, 1, 9, 0, 32'h40); cyc();
    // R7: no query -> quiet
    tag = "R7"; idle(); cyc();
    // R9: flush on matching early load, not otherwise
    tag = "R9"; idle(); res_valid = 1; res_load_early = 1;
    res_store_addr = 32'h80; res_load_addr = 32'h82; cyc();
    tag = "R9"; idle(); res_valid = 1; res_load_early = 0;
    res_store_addr = 32'h80; res_load_addr = 32'h80; cyc();
    tag = "R9"; idle(); res_valid = 1; res_load_early = 1;
    res_store_addr = 32'h80; res_load_addr = 32'h84; cyc();
    // R2: sticky across repeated sets and idle
    tag = "R2"; idle(); fwd_set_valid = 1; fwd_set_pc = 10'd5; cyc();
    idle(); cyc(); query(32'h0); set_slot(0, 1, 5, 0, 32'h0); cyc();
    // Mixed traffic over a small PC range
    tag = "R5";
    seed = 12345;
    for (int k = 0; k < 300; k++) begin
      idle();
      seed = seed * 1103515245 + 12345;
      fwd_set_valid = seed[20]; fwd_set_pc = IDX_W'(seed[27:24]);
      qry_valid = seed[21]; qry_load_addr = {24'h0, seed[15:8]};
      for (int s = 0; s < SLOTS; s++) begin
        seed = seed * 1103515245 + 12345;
        set_slot(s, seed[16], int'(seed[23:20]), seed[17], {24'h0, seed[15:8]});
      end
      res_valid = seed[25]; res_load_early = seed[26];
      res_store_addr = {28'h0, seed[31:28]}; res_load_addr = {28'h0, seed[7:4]};
      cyc();
    end
    // R1: reset clears table
    tag = "R1"; idle(); rst = 1; cyc(); rst = 0;
    query(32'h0); set_slot(0, 1, 5, 0, 32'h0); set_slot(1, 1, 9, 0, 32'h0); cyc();
    idle(); cyc();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule